// File: doc/BRIEF.md
# Time-of-Day Counter with Triggered Commands

This block keeps network time for an Ethernet timestamping path. The time value has three fields: 48 bits of seconds, 32 bits of nanoseconds and 32 bits of sub-nanosecond fraction. While the block is enabled, the time advances on every clock by a programmable step. A signed frequency trim adds to that step, so software can slew the clock without reprogramming the nominal period.

Software reaches the block through a simple 16-bit register port. Reads return data one cycle after the request. A 3-bit command field selects one operation: load a new time, change the trim, add an offset, subtract an offset, or capture the current time into one of two capture slots. The operation starts on a trigger. A trigger is either a host write that sets the trigger bit, or a rising edge on the external event input. The external input cannot be masked, so any edge on it runs whatever command is currently selected. The running seconds and nanoseconds also drive output ports, for use by timestamping logic.

Top module: `ptp_tod_core`

## Requirements
- R1: After `rstN` is released, the time reads zero and the status register reads zero. The time stays at zero until the enable register (address 1, bit 0) is written with 1.
- R2: While enable bit 0 is 0, the time is forced to zero on every clock and triggered commands are ignored.
- R3: On every enabled cycle with no time-changing command, the time advances in units of 2^-32 ns. The advance is the step whole-nanosecond register (address 3), plus the step fraction {address 4, address 5} taken as a signed value, plus the signed trim. When nanoseconds reach 1,000,000,000 or more, they wrap and one is carried into seconds.
- R4: The control register is at address 0. Bits [4:2] hold the command: 0 load, 1 frequency update, 2 add, 3 subtract, 4 capture, 7 no operation. A host trigger occurs only on a write to address 0 that sets bit 0 while the stored bit 0 is 0. The command takes effect on the clock after the write. In that cycle, load, add and subtract replace the step.
- R5: A load copies the load-value group into the time. The group is at addresses 8..14, in word order seconds high, mid, low, nanoseconds high, low, fraction high, low.
- R6: A frequency update takes the load-value fraction words as a signed trim in units of 2^-32 ns. The trim is then added to every later step.
- R7: An add sums the load-value time into the current time. A nanosecond result of 10^9 or more is reduced by 10^9 and carries one into seconds.
- R8: A subtract takes the load-value time from the current time. A negative nanosecond result has 10^9 added and borrows one from seconds.
- R9: A capture stores the current time in slot 0 when slot 0 is empty, and otherwise in slot 1, overwriting it. Status (address 2) bit 0 and bit 1 flag a valid slot 0 and slot 1. Slot words are at addresses 16..22 and 24..30, in the load-group word order.
- R10: Reading a slot's last word (address 22 or 30) clears that slot's valid flag. A capture into the same slot in the same cycle wins.
- R11: The external event input passes through two synchroniser flops. Its rising edge runs the selected command exactly once per edge, without any host trigger.
- R12: Control bit 8 (phase-update enable) reads back as written, and it is cleared when a load command is triggered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the time advances once per cycle |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| regWrEn | input | 1 | Register write request |
| regRdEn | input | 1 | Register read request |
| regAddr | input | 5 | Register word address |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data, valid the cycle after `regRdEn` |
| extEvent | input | 1 | Asynchronous external trigger |
| todSeconds | output | 48 | Current seconds |
| todNanos | output | 32 | Current nanoseconds |

## Verification
The nanosecond-range property assumes that every loaded or added nanosecond value is below 10^9 and that the net step is positive and below one second. The stimulus only loads such values, and its trims never outweigh the step. The read-clear property assumes reads are single-cycle requests that do not overlap a write. The bench drives every request for exactly one clock. The external event is held for several cycles and then released, so the synchroniser always sees one clean edge.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int REG_W      = 16;
  localparam int SEC_W      = 48;
  localparam int NS_W       = 32;
  localparam int FRAC_W     = 32;
  localparam int TOD_W      = SEC_W + NS_W + FRAC_W;
  localparam int SLOT_WORDS = TOD_W / REG_W;
  localparam int ADDR_W     = 5;
  localparam int NUM_SLOTS  = 2;

  localparam int ADR_CTRL    = 0;
  localparam int ADR_ENABLE  = 1;
  localparam int ADR_STATUS  = 2;
  localparam int ADR_STEP_NS = 3;
  localparam int ADR_STEP_FH = 4;
  localparam int ADR_STEP_FL = 5;
  localparam int ADR_LV_BASE = 8;
  localparam int ADR_CAP_BASE = 16;
  localparam int CAP_STRIDE  = 8;

  localparam int TRIG_BIT  = 0;
  localparam int CMD_LSB   = 2;
  localparam int CMD_MSB   = 4;
  localparam int PHASE_BIT = 8;

  typedef enum logic [2:0] {
    CMD_LOAD    = 3'd0,
    CMD_FREQ    = 3'd1,
    CMD_ADD     = 3'd2,
    CMD_SUB     = 3'd3,
    CMD_CAPTURE = 3'd4,
    CMD_NOP     = 3'd7
  } cmd_e;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [NS_W-1:0]   ns;
    logic [FRAC_W-1:0] frac;
  } tod_t;

  typedef struct packed {
    logic                 run;
    logic                 doLoad;
    logic                 doFreq;
    logic                 doAdd;
    logic                 doSub;
    logic                 doCapture;
    logic [NUM_SLOTS-1:0] clrSlot;
  } tod_strobe_t;

  typedef struct packed {
    logic [REG_W-1:0]  stepNs;
    logic [FRAC_W-1:0] stepFrac;
    tod_t              loadVal;
  } tod_cfg_t;
endpackage

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
#(
  parameter int unsigned NS_PER_SEC = 32'd1000000000
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  tod_strobe_t                strb,
  input  tod_cfg_t                   cfg,
  output tod_t                       tod,
  output tod_t [NUM_SLOTS-1:0]       capSlots,
  output logic [NUM_SLOTS-1:0]       slotValid
);
  localparam int FIX_W = NS_W + FRAC_W;
  localparam logic [NS_W-1:0] NS_LIMIT = NS_W'(NS_PER_SEC);

  logic [FRAC_W-1:0] trimReg;
  logic [FIX_W-1:0]  curFix, lvFix, stepInc, advFix;
  logic [NS_W-1:0]   advNs;
  logic              advWrap;
  logic [FIX_W:0]    addFix, subFix;
  logic [NS_W:0]     addNs;
  logic              addCarry, subBorrow;
  logic [NS_W-1:0]   subNs;
  tod_t              advRes, addRes, subRes, nextTod;
  logic [NUM_SLOTS-1:0] capSel;

  assign curFix = {tod.ns, tod.frac};
  assign lvFix  = {cfg.loadVal.ns, cfg.loadVal.frac};

  // nominal step plus signed step fraction plus signed trim
  assign stepInc = {{(NS_W-REG_W){1'b0}}, cfg.stepNs, {FRAC_W{1'b0}}}
                 + {{NS_W{cfg.stepFrac[FRAC_W-1]}}, cfg.stepFrac}
                 + {{NS_W{trimReg[FRAC_W-1]}}, trimReg};

  assign advFix  = curFix + stepInc;
  assign advNs   = advFix[FIX_W-1:FRAC_W];
  assign advWrap = advNs >= NS_LIMIT;

  always_comb begin
    advRes.frac = advFix[FRAC_W-1:0];
    advRes.ns   = advWrap ? advNs - NS_LIMIT : advNs;
    advRes.sec  = tod.sec + SEC_W'(advWrap);
  end

  assign addFix   = {1'b0, curFix} + {1'b0, lvFix};
  assign addNs    = addFix[FIX_W:FRAC_W];
  assign addCarry = addNs >= {1'b0, NS_LIMIT};

  always_comb begin
    addRes.frac = addFix[FRAC_W-1:0];
    addRes.ns   = addCarry ? NS_W'(addNs - {1'b0, NS_LIMIT}) : addNs[NS_W-1:0];
    addRes.sec  = tod.sec + cfg.loadVal.sec + SEC_W'(addCarry);
  end

  assign subFix    = {1'b0, curFix} - {1'b0, lvFix};
  assign subBorrow = subFix[FIX_W];
  assign subNs     = subFix[FIX_W-1:FRAC_W];

  always_comb begin
    subRes.frac = subFix[FRAC_W-1:0];
    subRes.ns   = subBorrow ? subNs + NS_LIMIT : subNs;
    subRes.sec  = tod.sec - cfg.loadVal.sec - SEC_W'(subBorrow);
  end

  always_comb begin
    if (!strb.run)          nextTod = '0;
    else if (strb.doLoad)   nextTod = cfg.loadVal;
    else if (strb.doAdd)    nextTod = addRes;
    else if (strb.doSub)    nextTod = subRes;
    else                    nextTod = advRes;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tod     <= '0;
      trimReg <= '0;
    end else begin
      tod <= nextTod;
      if (strb.doFreq) trimReg <= cfg.loadVal.frac;
    end
  end

  // lowest empty slot, else the last one
  always_comb begin
    logic found;
    capSel = '0;
    found  = 1'b0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (!slotValid[s] && !found) begin
        capSel[s] = 1'b1;
        found     = 1'b1;
      end
    end
    if (!found) capSel[NUM_SLOTS-1] = 1'b1;
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        capSlots[s]  <= '0;
        slotValid[s] <= 1'b0;
      end else if (strb.doCapture && capSel[s]) begin
        capSlots[s]  <= tod;
        slotValid[s] <= 1'b1;
      end else if (strb.clrSlot[s]) begin
        slotValid[s] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic                   regRdEn,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [REG_W-1:0]       regWrData,
  output logic [REG_W-1:0]       regRdData,
  input  logic                   extEvent,
  input  tod_t [NUM_SLOTS-1:0]   capSlots,
  input  logic [NUM_SLOTS-1:0]   slotValid,
  output tod_strobe_t            strb,
  output tod_cfg_t               cfg
);
  localparam int LAST_WORD = SLOT_WORDS - 1;
  localparam logic [REG_W-1:0] CTRL_RESET = REG_W'(CMD_NOP) << CMD_LSB;

  logic [REG_W-1:0] ctrlReg, stepNsReg, stepFracHi, stepFracLo;
  logic             enReg;
  logic [REG_W-1:0] lvWord [SLOT_WORDS];
  logic [TOD_W-1:0] lvFlat;
  logic [SYNC_STAGES:0] extPipe;
  logic             extRise, hostWrCtrl, hostTrig, fire;
  cmd_e             cmdNow;
  logic             loadQ, freqQ, addQ, subQ, capQ;
  logic [NUM_SLOTS-1:0] clrNow;
  logic [REG_W-1:0] rdMux;

  // event synchroniser with one extra flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extPipe <= '0;
    else       extPipe <= {extPipe[SYNC_STAGES-1:0], extEvent};
  end
  assign extRise = extPipe[SYNC_STAGES-1] & ~extPipe[SYNC_STAGES];

  assign hostWrCtrl = regWrEn && (regAddr == ADDR_W'(ADR_CTRL));
  assign hostTrig   = hostWrCtrl && regWrData[TRIG_BIT] && !ctrlReg[TRIG_BIT];
  assign cmdNow     = cmd_e'(hostWrCtrl ? regWrData[CMD_MSB:CMD_LSB]
                                        : ctrlReg[CMD_MSB:CMD_LSB]);
  assign fire       = (hostTrig || extRise) && enReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg    <= CTRL_RESET;
      enReg      <= 1'b0;
      stepNsReg  <= '0;
      stepFracHi <= '0;
      stepFracLo <= '0;
      for (int k = 0; k < SLOT_WORDS; k++) lvWord[k] <= '0;
    end else begin
      if (regWrEn) begin
        if (regAddr == ADDR_W'(ADR_CTRL))    ctrlReg    <= regWrData;
        if (regAddr == ADDR_W'(ADR_ENABLE))  enReg      <= regWrData[0];
        if (regAddr == ADDR_W'(ADR_STEP_NS)) stepNsReg  <= regWrData;
        if (regAddr == ADDR_W'(ADR_STEP_FH)) stepFracHi <= regWrData;
        if (regAddr == ADDR_W'(ADR_STEP_FL)) stepFracLo <= regWrData;
        for (int k = 0; k < SLOT_WORDS; k++) begin
          if (regAddr == ADDR_W'(ADR_LV_BASE + k)) lvWord[k] <= regWrData;
        end
      end
      if (fire && cmdNow == CMD_LOAD) ctrlReg[PHASE_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadQ <= 1'b0;
      freqQ <= 1'b0;
      addQ  <= 1'b0;
      subQ  <= 1'b0;
      capQ  <= 1'b0;
    end else begin
      loadQ <= fire && cmdNow == CMD_LOAD;
      freqQ <= fire && cmdNow == CMD_FREQ;
      addQ  <= fire && cmdNow == CMD_ADD;
      subQ  <= fire && cmdNow == CMD_SUB;
      capQ  <= fire && cmdNow == CMD_CAPTURE;
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_clr
    assign clrNow[s] = regRdEn &&
                       (regAddr == ADDR_W'(ADR_CAP_BASE + s * CAP_STRIDE + LAST_WORD));
  end

  always_comb begin
    strb.run       = enReg;
    strb.doLoad    = loadQ;
    strb.doFreq    = freqQ;
    strb.doAdd     = addQ;
    strb.doSub     = subQ;
    strb.doCapture = capQ;
    strb.clrSlot   = clrNow;
  end

  always_comb begin
    for (int k = 0; k < SLOT_WORDS; k++)
      lvFlat[(SLOT_WORDS-1-k)*REG_W +: REG_W] = lvWord[k];
  end

  assign cfg.stepNs   = stepNsReg;
  assign cfg.stepFrac = {stepFracHi, stepFracLo};
  assign cfg.loadVal  = tod_t'(lvFlat);

  always_comb begin
    logic [TOD_W-1:0] capFlat;
    rdMux = '0;
    if (regAddr == ADDR_W'(ADR_CTRL))    rdMux = ctrlReg;
    if (regAddr == ADDR_W'(ADR_ENABLE))  rdMux = {{(REG_W-1){1'b0}}, enReg};
    if (regAddr == ADDR_W'(ADR_STATUS))  rdMux = {{(REG_W-NUM_SLOTS){1'b0}}, slotValid};
    if (regAddr == ADDR_W'(ADR_STEP_NS)) rdMux = stepNsReg;
    if (regAddr == ADDR_W'(ADR_STEP_FH)) rdMux = stepFracHi;
    if (regAddr == ADDR_W'(ADR_STEP_FL)) rdMux = stepFracLo;
    for (int k = 0; k < SLOT_WORDS; k++) begin
      if (regAddr == ADDR_W'(ADR_LV_BASE + k)) rdMux = lvWord[k];
    end
    for (int s = 0; s < NUM_SLOTS; s++) begin
      capFlat = capSlots[s];
      for (int k = 0; k < SLOT_WORDS; k++) begin
        if (regAddr == ADDR_W'(ADR_CAP_BASE + s * CAP_STRIDE + k))
          rdMux = capFlat[(SLOT_WORDS-1-k)*REG_W +: REG_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        regRdData <= '0;
    else if (regRdEn) regRdData <= rdMux;
  end
endmodule

// File: rtl/ptp_tod_core.sv
module ptp_tod_core
  import tod_pkg::*;
#(
  parameter int unsigned NS_PER_SEC  = 32'd1000000000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              extEvent,
  output logic [SEC_W-1:0]  todSeconds,
  output logic [NS_W-1:0]   todNanos
);
  tod_strobe_t          strb;
  tod_cfg_t             cfg;
  tod_t                 tod;
  tod_t [NUM_SLOTS-1:0] capSlots;
  logic [NUM_SLOTS-1:0] slotValid;

  tod_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .extEvent(extEvent), .capSlots(capSlots), .slotValid(slotValid),
    .strb(strb), .cfg(cfg)
  );

  tod_datapath #(.NS_PER_SEC(NS_PER_SEC)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfg(cfg),
    .tod(tod), .capSlots(capSlots), .slotValid(slotValid)
  );

  assign todSeconds = tod.sec;
  assign todNanos   = tod.ns;
endmodule

// File: rtl/tod_checker.sv
module tod_checker
  import tod_pkg::*;
#(
  parameter int unsigned NS_PER_SEC = 32'd1000000000
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [SEC_W-1:0]     todSeconds,
  input logic [NS_W-1:0]      todNanos,
  input tod_strobe_t          strb,
  input logic [NUM_SLOTS-1:0] slotValid,
  input logic                 regRdEn,
  input logic [ADDR_W-1:0]    regAddr
);
  localparam logic [ADDR_W-1:0] SLOT0_LAST = ADDR_W'(ADR_CAP_BASE + SLOT_WORDS - 1);

  // R3: nanoseconds stay below one second once they are
  p_ns_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (todNanos < NS_PER_SEC) |=> (todNanos < NS_PER_SEC));

  // R2: soft reset forces the time to zero
  p_hold_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> (todNanos == '0 && todSeconds == '0));

  // R4: at most one command strobe per cycle
  p_one_cmd_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.doLoad, strb.doFreq, strb.doAdd, strb.doSub, strb.doCapture}));

  // R9: slot 1 only fills while slot 0 is occupied
  p_slot_order_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(slotValid[1]) |-> $past(slotValid[0]));

  // R10: reading slot 0's last word empties it unless a capture lands
  p_read_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == SLOT0_LAST && !strb.doCapture) |=> !slotValid[0]);
endmodule

bind ptp_tod_core tod_checker #(.NS_PER_SEC(NS_PER_SEC)) u_chk (
  .clk(clk), .rstN(rstN), .todSeconds(todSeconds), .todNanos(todNanos),
  .strb(strb), .slotValid(slotValid), .regRdEn(regRdEn), .regAddr(regAddr)
);

// File: tb/tb_ptp_tod_core.sv
module tb_ptp_tod_core;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_VEC = 7;
  // {step ns[15:0], step frac[31:0], trim[31:0], cycles[7:0]}
  localparam logic [87:0] VEC [NUM_VEC] = '{
    {16'd3, 32'h00000000, 32'h00000000, 8'd10},
    {16'd2, 32'hC0000000, 32'h00000000, 8'd4},
    {16'd7, 32'h80000000, 32'h00000000, 8'd2},
    {16'd1, 32'h40000000, 32'h00000000, 8'd3},
    {16'd3, 32'h00000000, 32'hC0000000, 8'd4},
    {16'd0, 32'h00000000, 32'h40000000, 8'd8},
    {16'd3, 32'h00000000, 32'h40000000, 8'd5}
  };
  localparam logic [15:0] C_LOAD = 16'd0 << 2, C_FREQ = 16'd1 << 2,
                          C_ADD  = 16'd2 << 2, C_SUB  = 16'd3 << 2,
                          C_CAP  = 16'd4 << 2, C_NOP  = 16'd7 << 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        extEvent = 1'b0;
  logic [47:0] todSeconds;
  logic [31:0] todNanos;
  int          checks = 0, errors = 0;
  logic [15:0] rv;

  ptp_tod_core dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .extEvent(extEvent), .todSeconds(todSeconds), .todNanos(todNanos)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(posedge clk); #1;
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic setLv(logic [47:0] s, logic [31:0] n, logic [31:0] f);
    wr(5'd8, s[47:32]);  wr(5'd9, s[31:16]); wr(5'd10, s[15:0]);
    wr(5'd11, n[31:16]); wr(5'd12, n[15:0]);
    wr(5'd13, f[31:16]); wr(5'd14, f[15:0]);
  endtask

  // trigger then restore: the command applies at the second write's edge
  task automatic cmd(logic [15:0] c);
    wr(5'd0, c | 16'd1);
    wr(5'd0, C_NOP);
  endtask

  task automatic extPulse();
    @(negedge clk); extEvent = 1'b1;
    repeat (4) @(negedge clk);
    extEvent = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [31:0] expNs(logic [15:0] sn, logic [31:0] sf,
                                        logic [31:0] tr, int n);
    logic [63:0] inc, tot;
    inc = {16'b0, sn, 32'b0} + {{32{sf[31]}}, sf} + {{32{tr[31]}}, tr};
    tot = inc * 64'(n);
    return tot[63:32];
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state and halted counter
    @(negedge clk);
    chk("R1", "ns after reset", todNanos, 0);
    chk("R1", "sec after reset", todSeconds, 0);
    rd(5'd2, rv); chk("R1", "status after reset", rv, 0);
    repeat (5) @(negedge clk);
    chk("R1", "ns before enable", todNanos, 0);

    // R3 / R6 table of step and trim settings
    for (int i = 0; i < NUM_VEC; i++) begin
      logic [15:0] sn; logic [31:0] sf, tr; int n;
      sn = VEC[i][87:72]; sf = VEC[i][71:40]; tr = VEC[i][39:8]; n = int'(VEC[i][7:0]);
      wr(5'd1, 16'd1);
      setLv(48'd0, 32'd0, tr);
      cmd(C_FREQ);
      wr(5'd1, 16'd0);
      wr(5'd3, sn); wr(5'd4, sf[31:16]); wr(5'd5, sf[15:0]);
      wr(5'd1, 16'd1);
      repeat (n) @(posedge clk);
      @(negedge clk);
      chk("R3_R6", $sformatf("vec%0d ns", i), todNanos, expNs(sn, sf, tr, n));
      chk("R3", $sformatf("vec%0d sec", i), todSeconds, 0);
    end

    // R2 soft reset holds zero and ignores commands
    wr(5'd1, 16'd0);
    repeat (3) @(negedge clk);
    chk("R2", "ns held", todNanos, 0);
    setLv(48'd0, 32'd500, 32'd0);
    cmd(C_LOAD);
    repeat (2) @(negedge clk);
    chk("R2", "load ignored", todNanos, 0);
    wr(5'd1, 16'd1);
    setLv(48'd0, 32'd0, 32'd0);
    cmd(C_FREQ);
    wr(5'd4, 16'd0); wr(5'd5, 16'd0);

    // R3 wrap with step 3
    wr(5'd3, 16'd3);
    setLv(48'd5, 32'd999999998, 32'd0);
    cmd(C_LOAD);
    chk("R5", "loaded ns", todNanos, 999999998);
    @(posedge clk); #1;
    chk("R3", "wrap ns", todNanos, 1);
    chk("R3", "wrap sec", todSeconds, 6);
    wr(5'd3, 16'd0);

    // R5 load
    setLv(48'h0001_0002_0003, 32'd123456789, 32'd0);
    cmd(C_LOAD);
    chk("R5", "load sec", todSeconds, 48'h0001_0002_0003);
    chk("R5", "load ns", todNanos, 123456789);

    // R7 add with carry
    setLv(48'd10, 32'd700000000, 32'd0); cmd(C_LOAD);
    setLv(48'd2, 32'd400000000, 32'd0);  cmd(C_ADD);
    chk("R7", "add ns", todNanos, 100000000);
    chk("R7", "add sec", todSeconds, 13);

    // R8 subtract with borrow
    setLv(48'd10, 32'd100000000, 32'd0); cmd(C_LOAD);
    setLv(48'd3, 32'd300000000, 32'd0);  cmd(C_SUB);
    chk("R8", "sub ns", todNanos, 800000000);
    chk("R8", "sub sec", todSeconds, 6);

    // R12 phase bit
    wr(5'd0, 16'h0100 | C_NOP);
    rd(5'd0, rv); chk("R12", "phase set", rv, 16'h0100 | C_NOP);
    wr(5'd0, 16'h0100 | C_LOAD | 16'd1);
    rd(5'd0, rv); chk("R12", "phase cleared by load", rv, 16'h0001);
    wr(5'd0, C_NOP);

    // R4 trigger only on a 0->1 write
    setLv(48'd0, 32'd0, 32'd0); cmd(C_LOAD);
    setLv(48'd0, 32'd5, 32'd0);
    wr(5'd0, C_ADD | 16'd1);
    @(posedge clk); #1;
    chk("R4", "first trigger", todNanos, 5);
    wr(5'd0, C_ADD | 16'd1);
    @(posedge clk); #1;
    chk("R4", "repeated bit no trigger", todNanos, 5);
    wr(5'd0, C_NOP);

    // R9 / R10 capture slots
    setLv(48'd7, 32'd1000, 32'd0); cmd(C_LOAD); cmd(C_CAP);
    rd(5'd2, rv);  chk("R9", "status one capture", rv, 1);
    rd(5'd20, rv); chk("R9", "slot0 ns", rv, 1000);
    rd(5'd18, rv); chk("R9", "slot0 sec", rv, 7);
    setLv(48'd7, 32'd2000, 32'd0); cmd(C_LOAD); cmd(C_CAP);
    rd(5'd2, rv);  chk("R9", "status two captures", rv, 3);
    rd(5'd28, rv); chk("R9", "slot1 ns", rv, 2000);
    setLv(48'd7, 32'd3000, 32'd0); cmd(C_LOAD); cmd(C_CAP);
    rd(5'd28, rv); chk("R9", "slot1 overwritten", rv, 3000);
    rd(5'd20, rv); chk("R9", "slot0 kept", rv, 1000);
    rd(5'd22, rv);
    rd(5'd2, rv);  chk("R10", "slot0 cleared", rv, 2);
    setLv(48'd7, 32'd4000, 32'd0); cmd(C_LOAD); cmd(C_CAP);
    rd(5'd2, rv);  chk("R9", "refill status", rv, 3);
    rd(5'd20, rv); chk("R9", "refill slot0", rv, 4000);
    rd(5'd30, rv);
    rd(5'd2, rv);  chk("R10", "slot1 cleared", rv, 1);

    // R11 external event runs selected command
    rd(5'd22, rv);
    rd(5'd2, rv);  chk("R10", "both empty", rv, 0);
    wr(5'd0, C_CAP);
    extPulse();
    rd(5'd2, rv);  chk("R11", "ext capture status", rv, 1);
    rd(5'd20, rv); chk("R11", "ext capture ns", rv, 4000);
    setLv(48'd0, 32'd10, 32'd0);
    wr(5'd0, C_ADD);
    extPulse();
    chk("R11", "ext add once", todNanos, 4010);
    wr(5'd0, C_NOP);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule